// File: doc/BRIEF.md
# SAD Block-Matching Motion Estimator

This block finds the motion vector of one square reference block of pixels by testing every candidate displacement inside a search window of a second frame. For each candidate it forms the sum of absolute differences (SAD) between the reference pixels and the candidate pixels. It reports the displacement with the lowest sum, together with that sum. A row of processing elements covers all horizontal displacements in parallel, with one element per horizontal offset. The same row is reused for one vertical displacement after another, so a block takes a fixed number of passes.

Use goes in two phases. First the reference block is loaded one row per handshake on the reference port. Then the window rows are streamed on the window port. For pass p (p = 0 .. NOFF-1), the source sends window rows p, p+1, ..., p+BLK-1 in that order, and each row is NOFF+BLK-1 pixels wide. When the last pass has been compared, the result is presented for one cycle and the block returns to accept a new reference block.

The controller has four states: LOAD_REF, ACCUM, COMPARE and DONE. LOAD_REF moves to ACCUM after BLK reference rows have been taken. ACCUM moves to COMPARE after BLK window rows have been taken. COMPARE moves back to ACCUM while passes remain, and to DONE after the final pass. DONE always moves to LOAD_REF.

Top module: `sadme_top`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `ref_ready` is 1 and `win_ready` is 0.
- R2: `ref_ready` stays high until exactly BLK reference rows have been accepted. Then `ref_ready` drops and `win_ready` rises. The two ready outputs are never high together. Pixel j of a row occupies bits [j*PIXW +: PIXW].
- R3: `out_sad` equals the minimum, over all NOFF x NOFF candidates, of the sum of |ref[r][j] - win[dyi+r][dxi+j]|. This holds up to the largest possible value BLK*BLK*(2^PIXW-1), without overflow.
- R4: The vector is two's complement, with `out_dx` = dxi - NOFF/2 and `out_dy` = dyi - NOFF/2. Here dxi is the window column and dyi is the window row of the best candidate's top-left pixel, so offsets span -NOFF/2 .. NOFF/2-1.
- R5: When candidates tie on SAD, the one with the smaller dy wins, and after that the one with the smaller dx.
- R6: `out_valid` rises exactly two cycles after the clock edge that accepts the final window row, and it lasts one cycle. A window beat with `win_valid` low does not advance the schedule.
- R7: `win_ready` is low for the single cycle that follows the last row of each pass.
- R8: After the result cycle, `ref_ready` is high again. The running minimum restarts, so a following block's result does not depend on the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Reference row valid |
| ref_ready | output | 1 | Reference row accepted when high with valid |
| ref_row | input | BLK*PIXW (64) | One reference row, pixel 0 in the LSBs |
| win_valid | input | 1 | Window row valid |
| win_ready | output | 1 | Window row accepted when high with valid |
| win_row | input | (NOFF+BLK-1)*PIXW (568) | One search-window row, pixel 0 in the LSBs |
| out_valid | output | 1 | One-cycle result pulse |
| out_dx | output | OFFW (6) | Best horizontal offset, signed |
| out_dy | output | OFFW (6) | Best vertical offset, signed |
| out_sad | output | ACCW (14) | Minimum SAD |

## Verification
A wrong accumulator or a wrong pixel alignment in one element corrupts `out_sad` or the vector on the very next result pulse. The bench catches this because it plants exact matches at the window corners and computes a full golden search on random data. A wrong pass or row counter shows up as `out_valid` arriving at the wrong cycle, or as `win_ready` failing to drop after a pass, and both are checked at every pass. A running minimum that is not reinitialised shows up on the next block as a stale, too-small SAD.

// File: rtl/sadme_pkg.sv
package sadme_pkg;
    typedef enum logic [1:0] {
        ST_LOAD_REF,
        ST_ACCUM,
        ST_COMPARE,
        ST_DONE
    } sadme_state_t;
endpackage

// File: rtl/sadme_pe.sv
// One processing element: accumulates the row-wise absolute differences
// for a single horizontal offset.
module sadme_pe #(
    parameter int PIXW = 8,
    parameter int BLK  = 8,
    parameter int ACCW = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic [BLK*PIXW-1:0] ref_px,
    input  logic [BLK*PIXW-1:0] cand_px,
    output logic [ACCW-1:0]     acc
);
    function automatic logic [PIXW-1:0] absdiff(input logic [PIXW-1:0] a,
                                                input logic [PIXW-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [ACCW-1:0] row_sum;

    always_comb begin
        row_sum = '0;
        for (int j = 0; j < BLK; j++) begin
            row_sum = row_sum + ACCW'(absdiff(ref_px[j*PIXW +: PIXW],
                                              cand_px[j*PIXW +: PIXW]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (en)
            acc <= acc + row_sum;
    end
endmodule

// File: rtl/sadme_minsel.sv
// Picks the smallest SAD across the element row; the lowest index wins ties.
module sadme_minsel #(
    parameter int NOFF = 64,
    parameter int ACCW = 14,
    parameter int IDXW = 6
) (
    input  logic [NOFF*ACCW-1:0] sads,
    output logic [ACCW-1:0]      min_sad,
    output logic [IDXW-1:0]      min_idx
);
    always_comb begin
        min_sad = sads[0 +: ACCW];
        min_idx = '0;
        for (int k = 1; k < NOFF; k++) begin
            if (sads[k*ACCW +: ACCW] < min_sad) begin
                min_sad = sads[k*ACCW +: ACCW];
                min_idx = IDXW'(k);
            end
        end
    end
endmodule

// File: rtl/sadme_top.sv
module sadme_top
    import sadme_pkg::*;
#(
    parameter int PIXW = 8,
    parameter int BLK  = 8,
    parameter int NOFF = 64,
    localparam int WROW = NOFF + BLK - 1,
    localparam int OFFW = $clog2(NOFF),
    localparam int ACCW = PIXW + $clog2(BLK * BLK)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_valid,
    output logic                 ref_ready,
    input  logic [BLK*PIXW-1:0]  ref_row,
    input  logic                 win_valid,
    output logic                 win_ready,
    input  logic [WROW*PIXW-1:0] win_row,
    output logic                 out_valid,
    output logic [OFFW-1:0]      out_dx,
    output logic [OFFW-1:0]      out_dy,
    output logic [ACCW-1:0]      out_sad
);
    localparam int ROWW = (BLK > 1) ? $clog2(BLK) : 1;
    localparam logic [OFFW-1:0] HALF = OFFW'(NOFF / 2);
    localparam logic [OFFW-1:0] LAST_PASS = OFFW'(NOFF - 1);

    sadme_state_t state, state_nx;

    logic [BLK*PIXW-1:0] ref_mem [BLK];
    logic [ROWW-1:0]     row_cnt;
    logic [OFFW-1:0]     pass_cnt;
    logic                pe_clr;
    logic                ref_fire, win_fire, row_last;
    logic [NOFF*ACCW-1:0] sads;
    logic [ACCW-1:0]     min_sad;
    logic [OFFW-1:0]     min_idx;
    logic [ACCW-1:0]     best_sad;
    logic [OFFW-1:0]     best_dx, best_dy;

    assign ref_fire = ref_valid && ref_ready;
    assign win_fire = win_valid && win_ready;
    assign row_last = (row_cnt == ROWW'(BLK - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LOAD_REF;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD_REF: if (ref_fire && row_last) state_nx = ST_ACCUM;
            ST_ACCUM:    if (win_fire && row_last) state_nx = ST_COMPARE;
            ST_COMPARE:  state_nx = (pass_cnt == LAST_PASS) ? ST_DONE : ST_ACCUM;
            ST_DONE:     state_nx = ST_LOAD_REF;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ref_ready = 1'b0;
        win_ready = 1'b0;
        out_valid = 1'b0;
        pe_clr    = 1'b0;
        unique case (state)
            ST_LOAD_REF: ref_ready = 1'b1;
            ST_ACCUM:    win_ready = 1'b1;
            ST_COMPARE:  pe_clr    = 1'b1;
            ST_DONE:     out_valid = 1'b1;
        endcase
    end

    assign out_dx  = best_dx;
    assign out_dy  = best_dy;
    assign out_sad = best_sad;

    // Counters and reference storage
    always_ff @(posedge clk) begin
        if (rst) begin
            row_cnt  <= '0;
            pass_cnt <= '0;
        end else begin
            if (ref_fire || win_fire)
                row_cnt <= row_last ? '0 : row_cnt + 1'b1;
            if (state == ST_COMPARE)
                pass_cnt <= pass_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ref_fire)
            ref_mem[row_cnt] <= ref_row;
    end

    // Running minimum; strict compare keeps the earlier (smaller dy) winner
    always_ff @(posedge clk) begin
        if (rst || state == ST_DONE) begin
            best_sad <= '1;
            best_dx  <= '0;
            best_dy  <= '0;
        end else if (state == ST_COMPARE && min_sad < best_sad) begin
            best_sad <= min_sad;
            best_dx  <= min_idx - HALF;
            best_dy  <= pass_cnt - HALF;
        end
    end

    // Processing-element row, one per horizontal offset
    for (genvar k = 0; k < NOFF; k++) begin : g_pe
        sadme_pe #(.PIXW(PIXW), .BLK(BLK), .ACCW(ACCW)) u_pe (
            .clk     (clk),
            .rst     (rst),
            .clr     (pe_clr),
            .en      (win_fire),
            .ref_px  (ref_mem[row_cnt]),
            .cand_px (win_row[k*PIXW +: BLK*PIXW]),
            .acc     (sads[k*ACCW +: ACCW])
        );
    end

    sadme_minsel #(.NOFF(NOFF), .ACCW(ACCW), .IDXW(OFFW)) u_minsel (
        .sads    (sads),
        .min_sad (min_sad),
        .min_idx (min_idx)
    );
endmodule

// File: rtl/sadme_checker.sv
module sadme_checker #(
    parameter int ACCW = 14,
    parameter int BLK  = 8,
    parameter int PIXW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ref_valid,
    input logic            ref_ready,
    input logic            win_ready,
    input logic            out_valid,
    input logic [ACCW-1:0] out_sad
);
    localparam logic [ACCW-1:0] SADMAX = ACCW'(BLK * BLK * ((1 << PIXW) - 1));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ref_ready && win_ready));

    a_r2_ref_wait: assert property (@(posedge clk) disable iff (rst)
        (ref_ready && !ref_valid) |=> ref_ready);

    a_r8_reload_after_done: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> ref_ready);

    a_r3_sad_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sad <= SADMAX));
endmodule

bind sadme_top sadme_checker #(.ACCW(ACCW), .BLK(BLK), .PIXW(PIXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_valid (ref_valid),
    .ref_ready (ref_ready),
    .win_ready (win_ready),
    .out_valid (out_valid),
    .out_sad   (out_sad)
);

// File: tb/sadme_top_bench.sv
`timescale 1ns/1ps
module sadme_top_bench;
    localparam int PIXW = 8;
    localparam int BLK  = 4;
    localparam int NOFF = 8;
    localparam int WROW = NOFF + BLK - 1;
    localparam int OFFW = 3;
    localparam int ACCW = 12;

    logic clk = 0;
    logic rst = 1;
    logic ref_valid = 0, win_valid = 0;
    logic ref_ready, win_ready, out_valid;
    logic [BLK*PIXW-1:0]  ref_row = '0;
    logic [WROW*PIXW-1:0] win_row = '0;
    logic [OFFW-1:0] out_dx, out_dy;
    logic [ACCW-1:0] out_sad;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] wpix [WROW][WROW];
    logic [7:0] rpix [BLK][BLK];

    always #2.5 clk = ~clk;

    sadme_top #(.PIXW(PIXW), .BLK(BLK), .NOFF(NOFF)) u_sadme_top (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row),
        .win_valid(win_valid), .win_ready(win_ready), .win_row(win_row),
        .out_valid(out_valid), .out_dx(out_dx), .out_dy(out_dy), .out_sad(out_sad)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic golden(output int esad, output int edx, output int edy);
        esad = 1 << 30; edx = 0; edy = 0;
        for (int dy = 0; dy < NOFF; dy++)
            for (int dx = 0; dx < NOFF; dx++) begin
                int s = 0;
                for (int r = 0; r < BLK; r++)
                    for (int j = 0; j < BLK; j++) begin
                        int a = rpix[r][j];
                        int b = wpix[dy+r][dx+j];
                        s += (a > b) ? a - b : b - a;
                    end
                if (s < esad) begin esad = s; edx = dx - NOFF/2; edy = dy - NOFF/2; end
            end
    endtask

    task automatic fill_random();
        for (int r = 0; r < WROW; r++)
            for (int c = 0; c < WROW; c++) wpix[r][c] = 8'($urandom);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++) rpix[r][c] = 8'($urandom);
    endtask

    task automatic plant(input int col, input int row);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++) wpix[row+r][col+c] = rpix[r][c];
    endtask

    task automatic fill_const(input int wv, input int rv);
        for (int r = 0; r < WROW; r++)
            for (int c = 0; c < WROW; c++) wpix[r][c] = 8'(wv);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++) rpix[r][c] = 8'(rv);
    endtask

    task automatic run_block(input int gap, input string tag);
        int esad, edx, edy;
        golden(esad, edx, edy);
        for (int r = 0; r < BLK; r++) begin
            @(negedge clk);
            ref_valid = 1;
            for (int j = 0; j < BLK; j++) ref_row[j*PIXW +: PIXW] = rpix[r][j];
            while (!ref_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        ref_valid = 0;
        chk("R2 ref_ready low after load", int'(ref_ready), 0);
        chk("R2 win_ready high after load", int'(win_ready), 1);
        for (int p = 0; p < NOFF; p++) begin
            for (int r = 0; r < BLK; r++) begin
                if (gap > 0) begin
                    @(negedge clk);
                    win_valid = 0;
                    repeat (gap - 1) @(negedge clk);
                end
                @(negedge clk);
                win_valid = 1;
                for (int c = 0; c < WROW; c++) win_row[c*PIXW +: PIXW] = wpix[p+r][c];
                while (!win_ready) @(negedge clk);
                @(posedge clk);
            end
            @(negedge clk);
            win_valid = 0;
            chk("R7 win_ready low after pass", int'(win_ready), 0);
            if (p == NOFF - 1)
                chk("R6 no early out_valid", int'(out_valid), 0);
        end
        @(negedge clk);
        chk("R6 out_valid two cycles after last row", int'(out_valid), 1);
        chk({"R3 sad ", tag}, int'(out_sad), esad);
        chk({"R4 R5 dx ", tag}, int'($signed(out_dx)), edx);
        chk({"R4 R5 dy ", tag}, int'($signed(out_dy)), edy);
        @(negedge clk);
        chk("R6 single-cycle pulse", int'(out_valid), 0);
        chk("R8 ref_ready after result", int'(ref_ready), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 ref_ready after reset", int'(ref_ready), 1);
        chk("R1 win_ready after reset", int'(win_ready), 0);

        for (int n = 0; n < 3; n++) begin
            fill_random();
            run_block(n, "random");
        end
        // R4 exact matches at the four window corners
        fill_random(); plant(0, 0);               run_block(0, "corner 0,0");
        fill_random(); plant(NOFF-1, NOFF-1);     run_block(1, "corner max,max");
        fill_random(); plant(NOFF-1, 0);          run_block(0, "corner max,0");
        fill_random(); plant(0, NOFF-1);          run_block(2, "corner 0,max");
        // R5 ties: different rows, then same row
        fill_random(); plant(5, 2); plant(1, 6);  run_block(0, "tie dy");
        fill_random(); plant(6, 3); plant(0, 3);  run_block(0, "tie dx");
        fill_const(77, 77);                       run_block(0, "all equal");
        // R3 largest SAD, then R8 back-to-back after a zero result
        fill_const(0, 255);                       run_block(0, "max sad");
        fill_const(9, 9);                         run_block(0, "zero");
        fill_const(255, 0);                       run_block(1, "max after zero");
        finish_run();
    end
endmodule